// File: doc/BRIEF.md
# SPI Master With Selectable Data-Line Modes

This block is the shift engine of an SPI master that can use its data lines in three ways, chosen at run time. In two-line full duplex, each SCLK period sends one bit on MOSI and samples one bit from MISO. In one-line half duplex, a single shared wire carries data, and a direction bit says whether the master drives it or listens on it. In simplex, the master either only sends or only receives. The master always uses clock mode 0: SCLK idles low, data is sampled on the rising edge and changed on the falling edge. Bits go out MSB first.

The host loads transmit bytes through a valid/ready handshake. Received bytes come back as a one-cycle strobe with the data beside it. In the modes that only receive, the host holds a receive-enable input high for as long as it wants bytes clocked in. A small control interface holds the mode, the direction, the receive-only bit, a slave-select enable and the SCLK divider. A write to it takes effect only once the engine is idle. The MOSI pin has an output-enable so that it can be tied to a tristate pad and share a wire with the slave.

Top module: `spi_duplex_master`

## Requirements
- R1: After reset, SCLK is low, ss_n is high, mosi_oe is low, rx_valid is low and tx_ready is high. The configuration is full duplex with slave select enabled and a divider of 3, so a byte sent with no configuration write is both transmitted and received.
- R2: In full duplex (cfg_mode 2'b00, and also 2'b11), each byte is shifted out on MOSI MSB first. In the same SCLK rising edges, 8 MISO bits are sampled MSB first, and they form rx_data.
- R3: SCLK stays high for cfg_div+1 system clocks and low for cfg_div+1 system clocks. One byte therefore keeps ss_n low for 16×(cfg_div+1) clocks and gives exactly 8 rising SCLK edges.
- R4: If the next byte is accepted (or, in receive-only modes, rx_en is still high) at the last falling edge of a byte, the transfer goes on with ss_n held low. When the transfer ends, SCLK is low and ss_n is released.
- R5: In half duplex with the master driving (cfg_mode 2'b01, cfg_half_tx 1), mosi_oe is high during the transfer, the byte appears on the line, and no rx_valid is raised.
- R6: In half duplex with the master listening (cfg_mode 2'b01, cfg_half_tx 0), mosi_oe stays low. Setting rx_en starts clocking, and the byte on the shared line is returned on rx_data.
- R7: In transmit-only simplex (cfg_mode 2'b10, cfg_rx_only 0), MOSI carries the byte and MISO is discarded: rx_valid never rises.
- R8: In receive-only simplex (cfg_mode 2'b10, cfg_rx_only 1), mosi_oe stays low and tx_ready stays low. Bytes are clocked in back to back while rx_en is high, and the byte in progress is finished after rx_en drops.
- R9: With cfg_ss_en at 0, ss_n stays high through the whole transfer, and data still moves.
- R10: A configuration write during a transfer does not change the ongoing transfer. It applies once the engine goes idle.
- R11: In the modes that receive, rx_valid is high for exactly one system clock per byte. It is raised at the eighth rising SCLK edge of the byte, when SCLK has just gone high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Write strobe for the configuration fields |
| cfg_mode | input | 2 | 00 full duplex, 01 half duplex, 10 simplex, 11 full duplex |
| cfg_half_tx | input | 1 | Half-duplex direction: 1 master drives, 0 master listens |
| cfg_rx_only | input | 1 | Simplex direction: 1 receive only, 0 transmit only |
| cfg_ss_en | input | 1 | Enables the slave-select output |
| cfg_div | input | DIV_W | SCLK half period minus one, in system clocks |
| tx_valid | input | 1 | Transmit byte offered |
| tx_data | input | DATA_W | Transmit byte |
| tx_ready | output | 1 | Byte accepted when high with tx_valid |
| rx_en | input | 1 | Keeps clocking bytes in the modes that only receive |
| rx_valid | output | 1 | One-cycle strobe for a received byte |
| rx_data | output | DATA_W | Received byte |
| sclk | output | 1 | Serial clock, idle low |
| ss_n | output | 1 | Active-low slave select |
| mosi | output | 1 | Serial data out |
| mosi_oe | output | 1 | Output-enable for the MOSI pad |
| miso | input | 1 | Serial data in (the shared line in half duplex) |

## Verification
If the bit counter is out of step, the wrong number of SCLK rising edges appears, or rx_valid comes one SCLK period early or late. This shows in the very first byte, as a shifted rx_data or MOSI pattern. A wrong live mode bit shows at once at mosi_oe or in a stray or missing rx_valid strobe during that byte. A wrong divider or phase register changes the number of clocks that ss_n is held low for a byte. An early or late config apply shows as a changed mosi_oe in the middle of a transfer, or as tx_ready in the idle cycles that follow it.

// File: rtl/spi_dm_pkg.sv
package spi_dm_pkg;
  typedef enum logic [1:0] {
    LINK_FULL    = 2'b00,
    LINK_HALF    = 2'b01,
    LINK_SIMPLEX = 2'b10,
    LINK_ALTFULL = 2'b11
  } link_mode_e;

  typedef struct packed {
    link_mode_e mode;
    logic       half_tx;
    logic       rx_only;
    logic       ss_en;
  } link_cfg_t;

  localparam link_cfg_t LINK_CFG_RESET = '{mode: LINK_FULL, half_tx: 1'b1,
                                           rx_only: 1'b0, ss_en: 1'b1};
endpackage

// File: rtl/spi_dm_cfg.sv
module spi_dm_cfg
  import spi_dm_pkg::*;
#(
  parameter int DIV_W     = 8,
  parameter int DIV_RESET = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  link_cfg_t        wr_cfg,
  input  logic [DIV_W-1:0] wr_div,
  input  logic             hold,
  output link_cfg_t        act_cfg,
  output logic [DIV_W-1:0] act_div,
  output logic             can_tx,
  output logic             can_rx
);
  link_cfg_t        pend_q, pend_d, act_q, act_d;
  logic [DIV_W-1:0] pdiv_q, pdiv_d, adiv_q, adiv_d;

  always_comb begin
    pend_d = pend_q;
    pdiv_d = pdiv_q;
    if (wr_en) begin
      pend_d = wr_cfg;
      pdiv_d = wr_div;
    end
    act_d  = hold ? act_q  : pend_q;
    adiv_d = hold ? adiv_q : pdiv_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= LINK_CFG_RESET;
      act_q  <= LINK_CFG_RESET;
      pdiv_q <= DIV_W'(DIV_RESET);
      adiv_q <= DIV_W'(DIV_RESET);
    end else begin
      pend_q <= pend_d;
      act_q  <= act_d;
      pdiv_q <= pdiv_d;
      adiv_q <= adiv_d;
    end
  end

  always_comb begin
    unique case (act_q.mode)
      LINK_HALF:    begin can_tx = act_q.half_tx;  can_rx = !act_q.half_tx; end
      LINK_SIMPLEX: begin can_tx = !act_q.rx_only; can_rx = act_q.rx_only;  end
      default:      begin can_tx = 1'b1;           can_rx = 1'b1;           end
    endcase
  end

  assign act_cfg = act_q;
  assign act_div = adiv_q;

  // R10: the live settings never move while a transfer holds them
  a_r10_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && $past(hold)) |-> ($stable(act_q) && $stable(adiv_q)));
endmodule

// File: rtl/spi_dm_clkgen.sv
module spi_dm_clkgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q, cnt_d;

  assign tick = run && (cnt_q == div);

  always_comb begin
    if (!run || tick) cnt_d = '0;
    else              cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R3: the half-period counter never passes the divider it was started with
  a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q <= div));
endmodule

// File: rtl/spi_dm_shifter.sv
module spi_dm_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              rise,
  input  logic              fall,
  input  logic              miso,
  input  logic              rx_keep,
  output logic              out_bit,
  output logic              byte_end,
  output logic              rx_valid,
  output logic [DATA_W-1:0] rx_data
);
  localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  logic [DATA_W-1:0] tx_q, tx_d, rx_q, rx_d, rdat_q, rdat_d;
  logic [CNT_W-1:0]  bit_q, bit_d;
  logic              rv_d, rv_q;
  logic [DATA_W-1:0] rx_next;

  assign byte_end = fall && (bit_q == LAST);
  assign rx_next  = {rx_q[DATA_W-2:0], miso};

  always_comb begin
    tx_d   = tx_q;
    bit_d  = bit_q;
    rx_d   = rx_q;
    rdat_d = rdat_q;
    rv_d   = 1'b0;
    if (load) begin
      tx_d  = load_data;
      bit_d = '0;
    end else if (fall && !byte_end) begin
      tx_d  = {tx_q[DATA_W-2:0], 1'b0};
      bit_d = bit_q + 1'b1;
    end
    if (rise) begin
      rx_d = rx_next;
      if (bit_q == LAST && rx_keep) begin
        rv_d   = 1'b1;
        rdat_d = rx_next;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q   <= '0;
      rx_q   <= '0;
      rdat_q <= '0;
      bit_q  <= '0;
      rv_q   <= 1'b0;
    end else begin
      tx_q   <= tx_d;
      rx_q   <= rx_d;
      rdat_q <= rdat_d;
      bit_q  <= bit_d;
      rv_q   <= rv_d;
    end
  end

  assign out_bit  = tx_q[DATA_W-1];
  assign rx_valid = rv_q;
  assign rx_data  = rdat_q;

  // R11: a receive strobe never lasts two clocks
  a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rv_q |=> !rv_q);
endmodule

// File: rtl/spi_duplex_master.sv
module spi_duplex_master
  import spi_dm_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int DIV_W     = 8,
  parameter int DIV_RESET = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_mode,
  input  logic              cfg_half_tx,
  input  logic              cfg_rx_only,
  input  logic              cfg_ss_en,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic              tx_valid,
  input  logic [DATA_W-1:0] tx_data,
  output logic              tx_ready,
  input  logic              rx_en,
  output logic              rx_valid,
  output logic [DATA_W-1:0] rx_data,
  output logic              sclk,
  output logic              ss_n,
  output logic              mosi,
  output logic              mosi_oe,
  input  logic              miso
);
  logic              rst_q1, rst_sync;
  logic              busy_q, busy_d, sclk_q, sclk_d;
  logic              tick, rise, fall, byte_end, out_bit;
  logic              can_tx, can_rx, want, start, cont, load;
  logic [DATA_W-1:0] load_data;
  link_cfg_t         wr_cfg, act_cfg;
  logic [DIV_W-1:0]  act_div;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q1   <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_q1   <= 1'b1;
      rst_sync <= rst_q1;
    end
  end

  assign wr_cfg = '{mode: link_mode_e'(cfg_mode), half_tx: cfg_half_tx,
                    rx_only: cfg_rx_only, ss_en: cfg_ss_en};

  spi_dm_cfg #(.DIV_W(DIV_W), .DIV_RESET(DIV_RESET)) u_cfg (
    .clk(clk), .rst_n(rst_sync), .wr_en(cfg_we), .wr_cfg(wr_cfg),
    .wr_div(cfg_div), .hold(busy_q || start), .act_cfg(act_cfg),
    .act_div(act_div), .can_tx(can_tx), .can_rx(can_rx));

  spi_dm_clkgen #(.DIV_W(DIV_W)) u_clk (
    .clk(clk), .rst_n(rst_sync), .run(busy_q), .div(act_div), .tick(tick));

  assign rise = tick && !sclk_q;
  assign fall = tick && sclk_q;

  // transmit-capable modes advance on host bytes, the others on rx_en
  assign want      = can_tx ? tx_valid : rx_en;
  assign start     = !busy_q && want;
  assign cont      = byte_end && want;
  assign load      = start || cont;
  assign load_data = can_tx ? tx_data : '0;
  assign tx_ready  = can_tx && (!busy_q || byte_end);

  spi_dm_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_sync), .load(load), .load_data(load_data),
    .rise(rise), .fall(fall), .miso(miso), .rx_keep(can_rx),
    .out_bit(out_bit), .byte_end(byte_end), .rx_valid(rx_valid),
    .rx_data(rx_data));

  always_comb begin
    busy_d = busy_q;
    if (start)                  busy_d = 1'b1;
    else if (byte_end && !cont) busy_d = 1'b0;
    sclk_d = sclk_q;
    if (!busy_q)   sclk_d = 1'b0;
    else if (tick) sclk_d = !sclk_q;
  end

  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync) begin
      busy_q <= 1'b0;
      sclk_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      sclk_q <= sclk_d;
    end
  end

  assign sclk    = sclk_q;
  assign ss_n    = !(busy_q && act_cfg.ss_en);
  assign mosi_oe = busy_q && can_tx;
  assign mosi    = mosi_oe && out_bit;

  // R11: the receive strobe coincides with SCLK freshly high
  a_r11_strobe_on_high: assert property (@(posedge clk) disable iff (!rst_sync)
    rx_valid |-> sclk_q);
  // R7: no strobe in a mode that does not receive
  a_r7_no_strobe_tx_only: assert property (@(posedge clk) disable iff (!rst_sync)
    rx_valid |-> can_rx);
  // R4: SCLK rests low whenever the engine is idle
  a_r4_idle_low: assert property (@(posedge clk) disable iff (!rst_sync)
    !busy_q |-> !sclk_q);
  // R3: SCLK holds between divider ticks
  a_r3_sclk_hold: assert property (@(posedge clk) disable iff (!rst_sync)
    (busy_q && !tick) |=> $stable(sclk_q));
  // R8: receive-only simplex never enables the MOSI driver
  a_r8_no_drive: assert property (@(posedge clk) disable iff (!rst_sync)
    (act_cfg.mode == LINK_SIMPLEX && act_cfg.rx_only) |-> !mosi_oe);
endmodule

// File: tb/test_spi_duplex_master.sv
`timescale 1ns/1ps
module test_spi_duplex_master;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0, cfg_half_tx = 1'b0, cfg_rx_only = 1'b0, cfg_ss_en = 1'b1;
  logic [1:0] cfg_mode = 2'b00;
  logic [7:0] cfg_div = 8'd0;
  logic       tx_valid = 1'b0, rx_en = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic       tx_ready, rx_valid, sclk, ss_n, mosi, mosi_oe, miso;
  logic [7:0] rx_data;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  spi_duplex_master i_spi_duplex_master (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_mode(cfg_mode),
    .cfg_half_tx(cfg_half_tx), .cfg_rx_only(cfg_rx_only), .cfg_ss_en(cfg_ss_en),
    .cfg_div(cfg_div), .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .rx_en(rx_en), .rx_valid(rx_valid), .rx_data(rx_data), .sclk(sclk),
    .ss_n(ss_n), .mosi(mosi), .mosi_oe(mosi_oe), .miso(miso));

  // slave model: presents bits that change on SCLK falling, records MOSI on rising
  logic [7:0]  slave_mem [16];
  logic [31:0] nfall = 0, nrise = 0, s_log = 0;
  always @(negedge sclk) nfall <= nfall + 1;
  always @(posedge sclk) begin
    nrise <= nrise + 1;
    s_log <= {s_log[30:0], mosi};
  end
  assign miso = slave_mem[nfall[6:3]][3'd7 - nfall[2:0]];

  // port monitors, sampled away from the active edge
  int oe_cnt = 0, ssl_cnt = 0, rxv_cnt = 0, rxv_hi = 0, rxv_bad = 0, ss_rise = 0;
  logic prev_rxv = 1'b0, prev_ss = 1'b1;
  logic [23:0] rx_log = 0;
  always @(negedge clk) begin
    oe_cnt  <= oe_cnt + int'(mosi_oe);
    ssl_cnt <= ssl_cnt + int'(!ss_n);
    rxv_hi  <= rxv_hi + int'(rx_valid);
    if (rx_valid && !prev_rxv) rxv_cnt <= rxv_cnt + 1;
    if (rx_valid && !sclk) rxv_bad <= rxv_bad + 1;
    if (rx_valid) rx_log <= {rx_log[15:0], rx_data};
    if (ss_n && !prev_ss) ss_rise <= ss_rise + 1;
    prev_rxv <= rx_valid;
    prev_ss  <= ss_n;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic write_cfg(input logic [1:0] m, input logic htx, input logic ronly,
                           input logic ssen, input logic [7:0] dv);
    cfg_mode = m; cfg_half_tx = htx; cfg_rx_only = ronly; cfg_ss_en = ssen;
    cfg_div = dv; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
    cycles(3);
  endtask

  task automatic send(input logic [7:0] b);
    tx_valid = 1'b1; tx_data = b;
    while (!tx_ready) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic receive_one();
    rx_en = 1'b1;
    cycles(2);
    rx_en = 1'b0;
  endtask

  function automatic logic [3:0] slot();
    return nfall[6:3];
  endfunction

  typedef struct packed {
    logic [1:0] mode;
    logic       htx;
    logic       ronly;
    logic [7:0] div;
    logic [7:0] txb;
    logic [7:0] rxb;
    logic       drives;
    logic       hears;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{2'b00, 1'b0, 1'b0, 8'd0, 8'hA5, 8'h3C, 1'b1, 1'b1},
    '{2'b00, 1'b0, 1'b0, 8'd2, 8'h81, 8'h7E, 1'b1, 1'b1},
    '{2'b01, 1'b1, 1'b0, 8'd1, 8'hC3, 8'h5F, 1'b1, 1'b0},
    '{2'b01, 1'b0, 1'b0, 8'd1, 8'h00, 8'h96, 1'b0, 1'b1},
    '{2'b10, 1'b0, 1'b0, 8'd0, 8'h5A, 8'hF0, 1'b1, 1'b0},
    '{2'b10, 1'b0, 1'b1, 8'd3, 8'h00, 8'h0F, 1'b0, 1'b1},
    '{2'b11, 1'b0, 1'b0, 8'd1, 8'h12, 8'hED, 1'b1, 1'b1}
  };

  int oe0, ssl0, rxv0, rise0, ssr0;
  task automatic snap();
    oe0 = oe_cnt; ssl0 = ssl_cnt; rxv0 = rxv_cnt; rise0 = nrise; ssr0 = ss_rise;
  endtask

  initial begin
    for (int i = 0; i < 16; i++) slave_mem[i] = 8'h00;
    cycles(3);
    // R1: outputs while reset is held
    check("R1 sclk in reset", sclk, 0);
    check("R1 ss_n in reset", ss_n, 1);
    check("R1 oe in reset", mosi_oe, 0);
    rst_n = 1'b1;
    cycles(4);
    check("R1 tx_ready after reset", tx_ready, 1);
    check("R1 rx_valid after reset", rx_valid, 0);

    // R1: defaults are full duplex, divider 3, select enabled
    slave_mem[slot()] = 8'hC9;
    snap();
    send(8'h6B); tx_valid = 1'b0;
    cycles(16 * 4 + 6);
    check("R1 default mosi", s_log[7:0], 8'h6B);
    check("R1 default rx", rx_log[7:0], 8'hC9);
    check("R1 default ss low time", ssl_cnt - ssl0, 64);

    // vector table walk: R2 R3 R5 R6 R7 R8
    for (int v = 0; v < 7; v++) begin
      vec_t t;
      t = VECS[v];
      write_cfg(t.mode, t.htx, t.ronly, 1'b1, t.div);
      slave_mem[slot()] = t.rxb;
      snap();
      if (t.drives) begin send(t.txb); tx_valid = 1'b0; end
      else receive_one();
      cycles(16 * (int'(t.div) + 1) + 6);
      check("R3 rising edges per byte", nrise - rise0, 8);
      check("R3 ss low per byte", ssl_cnt - ssl0, 16 * (int'(t.div) + 1));
      check("R5 R6 R8 oe follows mode", (oe_cnt - oe0) > 0, t.drives);
      check("R7 R11 strobe count", rxv_cnt - rxv0, int'(t.hears));
      if (t.drives) check("R2 R5 R7 mosi byte msb first", s_log[7:0], t.txb);
      if (t.hears)  check("R2 R6 R8 rx byte", rx_data, t.rxb);
    end

    // R4: three-byte burst in full duplex keeps select low throughout
    write_cfg(2'b00, 1'b0, 1'b0, 1'b1, 8'd1);
    slave_mem[slot()] = 8'h44; slave_mem[slot() + 4'd1] = 8'h55;
    slave_mem[slot() + 4'd2] = 8'h66;
    snap();
    send(8'h11); send(8'h22); send(8'h33); tx_valid = 1'b0;
    cycles(16 * 2 + 6);
    check("R4 burst select released once", ss_rise - ssr0, 1);
    check("R4 burst ss low time", ssl_cnt - ssl0, 3 * 32);
    check("R4 burst mosi", s_log[23:0], 24'h112233);
    check("R4 burst rx", rx_log, 24'h445566);
    check("R4 sclk idle low", sclk, 0);
    check("R4 ss_n released", ss_n, 1);

    // R8: receive-only keeps going while rx_en is high, finishes current byte
    write_cfg(2'b10, 1'b0, 1'b1, 1'b1, 8'd0);
    check("R8 tx_ready low in receive-only", tx_ready, 0);
    slave_mem[slot()] = 8'hA1; slave_mem[slot() + 4'd1] = 8'hB2;
    slave_mem[slot() + 4'd2] = 8'hC3;
    snap();
    rx_en = 1'b1;
    cycles(40);
    rx_en = 1'b0;
    cycles(30);
    check("R8 bytes clocked", rxv_cnt - rxv0, 3);
    check("R8 rx stream", rx_log, 24'hA1B2C3);
    check("R8 oe held low", oe_cnt - oe0, 0);
    check("R8 stops idle", ss_n, 1);

    // R9: select disabled
    write_cfg(2'b00, 1'b0, 1'b0, 1'b0, 8'd0);
    slave_mem[slot()] = 8'h3E;
    snap();
    send(8'hD4); tx_valid = 1'b0;
    cycles(22);
    check("R9 ss_n never low", ssl_cnt - ssl0, 0);
    check("R9 data still moves", s_log[7:0], 8'hD4);
    check("R9 rx still moves", rx_data, 8'h3E);

    // R10: a write in the middle of a byte waits for idle
    write_cfg(2'b00, 1'b0, 1'b0, 1'b1, 8'd3);
    slave_mem[slot()] = 8'h27;
    snap();
    send(8'h9C); tx_valid = 1'b0;
    cycles(10);
    write_cfg(2'b10, 1'b0, 1'b1, 1'b1, 8'd0);
    check("R10 oe kept mid transfer", mosi_oe, 1);
    cycles(64);
    check("R10 byte finished as full duplex", rx_data, 8'h27);
    check("R10 old divider kept", ssl_cnt - ssl0, 64);
    check("R10 new mode after idle", tx_ready, 0);

    // R11: strobe width and position over the whole run
    check("R11 one clock per strobe", rxv_hi, rxv_cnt);
    check("R11 strobe with sclk high", rxv_bad, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 100000; i++) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule